// File: doc/BRIEF.md
# Power-of-Two Chip Select Decoder

This block turns a local-bus address into a set of active-low chip selects. Each chip select is governed by one configuration word that packs three things together: an enable flag in bit 0, a size marker given by the lowest set bit above bit 0, and a base address made of every bit above that marker. Because the window size is implied by where the marker sits, the decoder has to find the lowest set bit of each word before it can build the compare mask. Windows are always powers of two and naturally aligned.

Beside the chip selects, the block checks whether an address falls inside one local space. That space is described by a range word holding the two's complement of the space size (a high-bits mask) and a remap word holding the space base, which must be a multiple of the size. The result comes out as an active-high hit flag with the same timing as the chip selects.

Software loads all words through a simple indexed write port and reads them back through an indexed read port. An address strobe launches a bus cycle; the decode is captured at that edge and held until the cycle-end input arrives.

Top module: `pow2_cs_decoder`

## Requirements
- R1: While reset is low, every chip-select output is high, the space hit flag is low, and afterwards every configuration word reads back as zero.
- R2: A write with index 0..NUM_CS-1 loads a chip-select word, index NUM_CS loads the space range word and index NUM_CS+1 loads the space remap word; only the low AW data bits are kept, read data bits DW-1..AW read as zero, writes to any higher index are ignored and reads of any higher index return zero.
- R3: A chip select whose word has bit 0 clear never asserts.
- R4: With bit 0 set and k the lowest set bit among bits AW-1..1, the chip select matches when address bits AW-1..k+1 equal word bits AW-1..k+1; for example word 0x0026001 matches 0x0024000 through 0x0027FFF and nothing else.
- R5: A word with bit 0 set and all other bits clear matches no address.
- R6: A chip select goes low in the cycle after the clock edge that samples the address strobe high with a matching address, stays low while neither strobe nor cycle end is sampled, and goes high after the edge that samples cycle end high without a strobe; a strobe sampled together with cycle end starts the new decode.
- R7: When several chip selects match the same address they all assert together, with no priority between them.
- R8: The space hit flag is set under the timing of R6 when the address ANDed with the range word equals the remap word ANDed with the range word.
- R9: A configuration write during an active cycle leaves the held outputs unchanged until the next strobe; a write in the same edge as a strobe does not affect that strobe's decode.
- R10: The marker may sit at either extreme: at bit AW-1 the window covers every address, at bit 1 the window is four bytes wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Configuration write enable |
| reg_wr_idx | input | IW | Index of the word to write |
| reg_wr_data | input | DW | Write data |
| reg_rd_idx | input | IW | Index of the word to read |
| reg_rd_data | output | DW | Read data, combinational from the index |
| addr_strobe | input | 1 | Starts a bus cycle; address is decoded at this edge |
| local_addr | input | AW | Local-bus address |
| cycle_end | input | 1 | Ends the current bus cycle |
| cs_n | output | NUM_CS | Registered active-low chip selects |
| space_hit | output | 1 | Registered local-space hit flag |

## Verification
The properties treat addr_strobe and cycle_end as synchronous levels that may arrive in any combination, including both at once, and make no assumption about configuration contents except for the disabled and bare-enable cases they single out. The space hit is only meaningful when the range word is a valid power-of-two complement and the remap word is aligned to it, so the stimulus loads only such pairs (plus the all-zero reset value, which covers every address). The chip-select words, by contrast, are driven with overlapping, disabled, bare-enable and extreme-marker settings, and strobes and cycle ends are placed back to back and together to probe the hold and restart rules.

// File: rtl/pow2_csd_pkg.sv
package pow2_csd_pkg;

   // Implementation choice for the lowest-set-bit search that sizes a window.
   typedef enum logic [0:0] {
      MASK_ARITH = 1'b0,  // isolate the lowest set bit with a two's complement trick
      MASK_SCAN  = 1'b1   // explicit bit-by-bit priority scan
   } mask_style_e;

   // Held state of one decoded bus cycle.
   typedef struct packed {
      logic active;
      logic hit;
   } held_flag_t;

endpackage

// File: rtl/csd_regs.sv
module csd_regs #(
   parameter int AW     = 28,
   parameter int DW     = 32,
   parameter int NUM_CS = 4,
   localparam int NREG  = NUM_CS + 2,
   localparam int IW    = $clog2(NREG)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IW-1:0]                wr_idx,
   input  logic [DW-1:0]                wr_data,
   input  logic [IW-1:0]                rd_idx,
   output logic [DW-1:0]                rd_data,
   output logic [NUM_CS-1:0][AW-1:0]    cs_cfg,
   output logic [AW-1:0]                spc_range,
   output logic [AW-1:0]                spc_remap
);

   logic [NREG-1:0][AW-1:0] store;

   // One register per word; each decodes its own index.
   for (genvar r = 0; r < NREG; r++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            store[r] <= '0;
         end else if (wr_en && (wr_idx == IW'(r))) begin
            store[r] <= wr_data[AW-1:0];
         end
      end
   end

   for (genvar c = 0; c < NUM_CS; c++) begin : g_cs_out
      assign cs_cfg[c] = store[c];
   end

   assign spc_range = store[NUM_CS];
   assign spc_remap = store[NUM_CS+1];

   // Readback: unused upper data bits are zero, unmapped indices read zero.
   always_comb begin
      rd_data = '0;
      for (int r = 0; r < NREG; r++) begin
         if (rd_idx == IW'(r)) begin
            rd_data[AW-1:0] = store[r];
         end
      end
   end

endmodule

// File: rtl/csd_window.sv
module csd_window
   import pow2_csd_pkg::*;
#(
   parameter int          AW    = 28,
   parameter mask_style_e STYLE = MASK_ARITH
) (
   input  logic [AW-1:0] cfg,
   input  logic [AW-1:0] addr,
   output logic          hit
);

   logic [AW-1:0] body;
   logic [AW-1:0] cmp_mask;
   logic          sized;

   // Enable bit is removed before looking for the size marker.
   assign body = {cfg[AW-1:1], 1'b0};

   if (STYLE == MASK_ARITH) begin : g_arith
      logic [AW-1:0] lowest;
      assign lowest   = body & (~body + AW'(1));
      assign cmp_mask = ~(lowest | (lowest - AW'(1)));
      assign sized    = |body;
   end else begin : g_scan
      always_comb begin
         cmp_mask = '0;
         sized    = 1'b0;
         // Walk downward so the last bit seen is the lowest set one.
         for (int b = AW - 1; b >= 1; b--) begin
            if (cfg[b]) begin
               cmp_mask = {AW{1'b1}} << (b + 1);
               sized    = 1'b1;
            end
         end
      end
   end

   assign hit = cfg[0] & sized & ((addr & cmp_mask) == (cfg & cmp_mask));

endmodule

// File: rtl/csd_space.sv
module csd_space #(
   parameter int AW = 28
) (
   input  logic [AW-1:0] range_word,
   input  logic [AW-1:0] remap_word,
   input  logic [AW-1:0] addr,
   output logic          hit
);

   // The range word is the negated size, so it is already the high-bits mask.
   assign hit = ((addr ^ remap_word) & range_word) == '0;

endmodule

// File: rtl/pow2_cs_decoder.sv
module pow2_cs_decoder
   import pow2_csd_pkg::*;
#(
   parameter int          AW     = 28,
   parameter int          DW     = 32,
   parameter int          NUM_CS = 4,
   parameter mask_style_e STYLE  = MASK_ARITH,
   localparam int         NREG   = NUM_CS + 2,
   localparam int         IW     = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [IW-1:0]     reg_wr_idx,
   input  logic [DW-1:0]     reg_wr_data,
   input  logic [IW-1:0]     reg_rd_idx,
   output logic [DW-1:0]     reg_rd_data,
   input  logic              addr_strobe,
   input  logic [AW-1:0]     local_addr,
   input  logic              cycle_end,
   output logic [NUM_CS-1:0] cs_n,
   output logic              space_hit
);

   // Elaboration-time parameter checks.
   if (AW < 2) begin : g_bad_aw
      $error("pow2_cs_decoder: AW must be at least 2");
   end
   if (DW < AW) begin : g_bad_dw
      $error("pow2_cs_decoder: DW must not be narrower than AW");
   end
   if (NUM_CS < 1) begin : g_bad_n
      $error("pow2_cs_decoder: NUM_CS must be at least 1");
   end

   logic [NUM_CS-1:0][AW-1:0] cs_cfg;
   logic [AW-1:0]             spc_range;
   logic [AW-1:0]             spc_remap;
   logic [NUM_CS-1:0]         cs_match;
   logic                      spc_match;
   held_flag_t [NUM_CS-1:0]   cs_held;
   held_flag_t                spc_held;

   csd_regs #(
      .AW     (AW),
      .DW     (DW),
      .NUM_CS (NUM_CS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .wr_idx    (reg_wr_idx),
      .wr_data   (reg_wr_data),
      .rd_idx    (reg_rd_idx),
      .rd_data   (reg_rd_data),
      .cs_cfg    (cs_cfg),
      .spc_range (spc_range),
      .spc_remap (spc_remap)
   );

   for (genvar c = 0; c < NUM_CS; c++) begin : g_win
      csd_window #(
         .AW    (AW),
         .STYLE (STYLE)
      ) u_win (
         .cfg  (cs_cfg[c]),
         .addr (local_addr),
         .hit  (cs_match[c])
      );

      // Decode captured at the strobe, held until cycle end.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cs_held[c] <= '0;
         end else if (addr_strobe) begin
            cs_held[c].active <= 1'b1;
            cs_held[c].hit    <= cs_match[c];
         end else if (cycle_end) begin
            cs_held[c] <= '0;
         end
      end

      assign cs_n[c] = ~(cs_held[c].active & cs_held[c].hit);
   end

   csd_space #(
      .AW (AW)
   ) u_space (
      .range_word (spc_range),
      .remap_word (spc_remap),
      .addr       (local_addr),
      .hit        (spc_match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spc_held <= '0;
      end else if (addr_strobe) begin
         spc_held.active <= 1'b1;
         spc_held.hit    <= spc_match;
      end else if (cycle_end) begin
         spc_held <= '0;
      end
   end

   assign space_hit = spc_held.active & spc_held.hit;

endmodule

// File: rtl/pow2_cs_decoder_chk.sv
module pow2_cs_decoder_chk #(
   parameter int AW     = 28,
   parameter int NUM_CS = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      addr_strobe,
   input logic                      cycle_end,
   input logic [NUM_CS-1:0]         cs_n,
   input logic                      space_hit,
   input logic [NUM_CS-1:0][AW-1:0] cs_cfg
);

   for (genvar c = 0; c < NUM_CS; c++) begin : g_per_cs
      p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (addr_strobe && !cs_cfg[c][0]) |=> cs_n[c]);

      p_bare_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (addr_strobe && (cs_cfg[c] == AW'(1))) |=> cs_n[c]);

      p_start_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(cs_n[c]) |-> $past(addr_strobe));
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_strobe && !cycle_end) |=> ($stable(cs_n) && $stable(space_hit)));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_strobe && cycle_end) |=> ((&cs_n) && !space_hit));

   p_space_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(space_hit) |-> $past(addr_strobe));

endmodule

bind pow2_cs_decoder pow2_cs_decoder_chk #(
   .AW     (AW),
   .NUM_CS (NUM_CS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_strobe (addr_strobe),
   .cycle_end   (cycle_end),
   .cs_n        (cs_n),
   .space_hit   (space_hit),
   .cs_cfg      (cs_cfg)
);

// File: tb/pow2_cs_decoder_bench.sv
module pow2_cs_decoder_bench;

   localparam int AW    = 28;
   localparam int DW    = 32;
   localparam int NCS   = 4;
   localparam int IW    = 3;
   localparam int NREG  = NCS + 2;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           reg_wr;
   logic [IW-1:0]  reg_wr_idx;
   logic [DW-1:0]  reg_wr_data;
   logic [IW-1:0]  reg_rd_idx;
   logic [DW-1:0]  reg_rd_data;
   logic           addr_strobe;
   logic [AW-1:0]  local_addr;
   logic           cycle_end;
   logic [NCS-1:0] cs_n;
   logic           space_hit;

   pow2_cs_decoder #(.AW(AW), .DW(DW), .NUM_CS(NCS)) u_pow2_cs_decoder (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_wr_idx  (reg_wr_idx),
      .reg_wr_data (reg_wr_data),
      .reg_rd_idx  (reg_rd_idx),
      .reg_rd_data (reg_rd_data),
      .addr_strobe (addr_strobe),
      .local_addr  (local_addr),
      .cycle_end   (cycle_end),
      .cs_n        (cs_n),
      .space_hit   (space_hit)
   );

   always #10 clk = ~clk;  // 50 MHz

   int    vectors = 0;
   int    miscompares = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // Behavioural reference state.
   longint unsigned mreg [NREG];
   bit [NCS-1:0]    m_cs;
   bit              m_spc;

   function automatic bit ref_cs(longint unsigned w, longint unsigned a);
      if (w[0] == 1'b0) return 1'b0;
      for (int b = 1; b < AW; b++) begin
         if (w[b]) return ((a >> (b + 1)) == (w >> (b + 1)));
      end
      return 1'b0;
   endfunction

   function automatic bit ref_space(longint unsigned rng, longint unsigned base,
                                    longint unsigned a);
      longint unsigned size;
      size = (rng == 0) ? (64'd1 << AW) : ((64'd1 << AW) - rng);
      return (a >= base) && (a < base + size);
   endfunction

   function automatic longint unsigned ref_read(int idx);
      if (idx < NREG) return mreg[idx];
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mreg[i] = 0;
         m_cs  = '0;
         m_spc = 1'b0;
      end else begin
         if (addr_strobe) begin
            for (int i = 0; i < NCS; i++) m_cs[i] = ref_cs(mreg[i], local_addr);
            m_spc = ref_space(mreg[NCS], mreg[NCS+1], local_addr);
         end else if (cycle_end) begin
            m_cs  = '0;
            m_spc = 1'b0;
         end
         if (reg_wr && (int'(reg_wr_idx) < NREG))
            mreg[reg_wr_idx] = longint'(reg_wr_data) & ((64'd1 << AW) - 1);
      end
      #5;
      if (!done) begin
         vectors++;
         if (cs_n !== ~m_cs) begin
            miscompares++;
            $display("FAIL %s cs_n actual=%b expected=%b", cur_req, cs_n, ~m_cs);
         end
         if (space_hit !== m_spc) begin
            miscompares++;
            $display("FAIL %s space_hit actual=%b expected=%b", cur_req, space_hit, m_spc);
         end
         if (longint'(reg_rd_data) !== ref_read(int'(reg_rd_idx))) begin
            miscompares++;
            $display("FAIL %s rd_data[%0d] actual=%h expected=%h", cur_req,
                     reg_rd_idx, reg_rd_data, ref_read(int'(reg_rd_idx)));
         end
      end
   end

   task automatic drive(input logic wr, input int widx, input logic [DW-1:0] wdata,
                        input int ridx, input logic stb, input logic [AW-1:0] a,
                        input logic ce);
      @(negedge clk);
      reg_wr      = wr;
      reg_wr_idx  = IW'(widx);
      reg_wr_data = wdata;
      reg_rd_idx  = IW'(ridx);
      addr_strobe = stb;
      local_addr  = a;
      cycle_end   = ce;
   endtask

   task automatic wr_word(input int idx, input logic [DW-1:0] d);
      drive(1'b1, idx, d, idx, 1'b0, '0, 1'b0);
      drive(1'b0, 0, '0, idx, 1'b0, '0, 1'b0);
   endtask

   // One full bus cycle: strobe, two held cycles, end, one idle.
   task automatic bus_cycle(input logic [AW-1:0] a);
      drive(1'b0, 0, '0, 0, 1'b1, a, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b1);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0;
      reg_wr = 1'b0; reg_wr_idx = '0; reg_wr_data = '0; reg_rd_idx = '0;
      addr_strobe = 1'b0; local_addr = '0; cycle_end = 1'b0;
      cur_req = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) drive(1'b0, 0, '0, i, 1'b0, '0, 1'b0);

      // R2: field truncation, index map, unmapped index.
      cur_req = "R2";
      wr_word(0, 32'hF002_6001);
      wr_word(7, 32'h0FFF_FFFF);
      for (int i = 0; i < 8; i++) drive(1'b0, 0, '0, i, 1'b0, '0, 1'b0);

      // R4: window 0x24000..0x27FFF for word 0x0026001.
      cur_req = "R4";
      bus_cycle(28'h0024000);
      bus_cycle(28'h0027FFF);
      bus_cycle(28'h0023FFF);
      bus_cycle(28'h0028000);
      bus_cycle(28'h0025ABC);

      // R3: marker present, enable clear.
      cur_req = "R3";
      wr_word(1, 32'h0100000);
      bus_cycle(28'h0100004);
      bus_cycle(28'h0000000);

      // R5: bare enable.
      cur_req = "R5";
      wr_word(2, 32'h1);
      bus_cycle(28'h0000000);
      bus_cycle(28'h0000001);
      bus_cycle(28'hFFFFFFF);

      // R7: overlapping windows 0x20000..0x27FFF and 0x24000..0x27FFF.
      cur_req = "R7";
      wr_word(3, 32'h0024001);
      bus_cycle(28'h0025000);
      bus_cycle(28'h0021000);

      // R10: marker at the top bit and at bit 1.
      cur_req = "R10";
      wr_word(1, 32'h8000001);
      wr_word(2, 32'h0000003);
      bus_cycle(28'hABCDEF0);
      bus_cycle(28'h0000003);
      bus_cycle(28'h0000004);

      // R8: space of 0x1000 bytes at 0x0345000.
      cur_req = "R8";
      wr_word(NCS, 32'h0FFF_F000);
      wr_word(NCS + 1, 32'h0034_5000);
      bus_cycle(28'h0345000);
      bus_cycle(28'h0345FFF);
      bus_cycle(28'h0346000);
      bus_cycle(28'h0344FFF);

      // R6: strobe with cycle end together, back-to-back strobes, long hold.
      cur_req = "R6";
      drive(1'b0, 0, '0, 0, 1'b1, 28'h0024010, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b1, 28'h0000002, 1'b1);
      drive(1'b0, 0, '0, 0, 1'b1, 28'h0345010, 1'b0);
      for (int i = 0; i < 6; i++) drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b1);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b1);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b0);

      // R9: writes during a held cycle and on the strobe edge itself.
      cur_req = "R9";
      drive(1'b0, 0, '0, 0, 1'b1, 28'h0025000, 1'b0);
      drive(1'b1, 0, 32'h0, 0, 1'b0, '0, 1'b0);
      drive(1'b1, 3, 32'h0, 3, 1'b0, '0, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b1);
      drive(1'b1, 0, 32'h0026001, 0, 1'b1, 28'h0026000, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b0);
      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b1);
      bus_cycle(28'h0026000);

      drive(1'b0, 0, '0, 0, 1'b0, '0, 1'b0);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog expired during %s", cur_req);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule